// File: doc/BRIEF.md
# CAN Controller Interrupt Unit

This block turns the status and event signals of a CAN protocol core into a single active-low interrupt request for the host processor. Software selects which sources may interrupt through an 8-bit enable register. Events from enabled sources are captured in a flag register. A read of the flag register clears the captured events.

Two kinds of source exist. The receive source is a level: it asserts the interrupt for as long as the receive buffer reports full data and its enable is set. It stops as soon as either condition goes away. Every other source is a captured event. Some of them are one-cycle pulses from the core (transmission done, arbitration lost, bus error). Others are changes of a status level that the unit detects itself against a registered copy of the previous value. The overrun event and the transmit-buffer-free event fire only on a rising level. The warning event and the error-passive event fire on a change in either direction.

The host reaches the unit through a simple register port with separate write and read strobes. Read data returns one cycle after the read strobe, qualified by a valid flag.

Top module: `can_irq_unit`

## Requirements
- R1: After reset, the enable register and all captured flags are 0, `irq_n` is 1, and a read of either register returns 0.
- R2: The enable register is at address 0x10. Its bit layout is: bit 0 receive, bit 1 transmit, bit 2 warning, bit 3 overrun, bit 5 error passive, bit 6 arbitration lost, bit 7 bus error. Bit 4 and bits 31:8 ignore writes and read as 0.
- R3: Flag bit 0 and the interrupt follow `rx_full` AND enable bit 0 with no storage. If enable bit 0 is cleared while nothing else is pending, `irq_n` is 1 in the cycle after the write edge.
- R4: A `tx_done` pulse sets flag bit 1. A 0-to-1 change of `tx_buf_free` also sets flag bit 1. A 1-to-0 change of `tx_buf_free` sets nothing.
- R5: Any change of `bus_status` or `err_status`, in either direction, sets flag bit 2.
- R6: A 0-to-1 change of `data_overrun` sets flag bit 3. A 1-to-0 change sets nothing.
- R7: Any change of `err_passive`, in either direction, sets flag bit 5.
- R8: An `arb_lost` pulse sets flag bit 6. A `bus_error` pulse sets flag bit 7.
- R9: An event that arrives while its enable bit is 0 is dropped. Setting the enable afterwards does not raise a flag for it.
- R10: The flag register is read at address 0x0C and uses the same bit layout as the enable register. The read returns the flags as they stood in the read cycle. It then clears flag bits 1 to 7, except that an event arriving in the same cycle stays set.
- R11: `irq_n` is 0 exactly when some flag bit is set, and 1 otherwise.
- R12: While the status inputs hold their reset values, enabling all sources after reset raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rx_full | input | 1 | Receive buffer holds a message (level) |
| data_overrun | input | 1 | Receive overrun status (level) |
| err_status | input | 1 | Error counter warning status (level) |
| bus_status | input | 1 | Bus-off status (level) |
| err_passive | input | 1 | Controller is error passive (level) |
| tx_done | input | 1 | Transmission completed (one-cycle pulse) |
| tx_buf_free | input | 1 | Transmit buffer accessible (level) |
| arb_lost | input | 1 | Arbitration lost (one-cycle pulse) |
| bus_error | input | 1 | Bus error detected (one-cycle pulse) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the unit with its default parameters: 8-bit addresses, 32-bit data, the enable register at 0x10, the flag register at 0x0C, and all tracked status levels resetting to 0. It holds every status input at 0 through reset. That makes the no-spurious-interrupt case after reset directly observable. With 32-bit data the bench can write all ones and confirm that only the seven defined enable bits stick. The bench then drives each tracked level in both directions. This separates the sources that must fire on either change from those that fire only on a rise. It also issues a flag read in the same cycle as a new event, to show that setting an event takes priority over the clear-on-read.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned SRC_RX   = 0;
  localparam int unsigned SRC_TX   = 1;
  localparam int unsigned SRC_WARN = 2;
  localparam int unsigned SRC_OVR  = 3;
  localparam int unsigned SRC_RSVD = 4;
  localparam int unsigned SRC_PASV = 5;
  localparam int unsigned SRC_ARB  = 6;
  localparam int unsigned SRC_BERR = 7;

  // writable enable bits: everything except the reserved position
  localparam logic [NUM_SRC-1:0] EN_MASK = ~(NUM_SRC'(1) << SRC_RSVD);

  // status levels whose previous value is tracked for change detection
  typedef struct packed {
    logic tx_free;
    logic passive;
    logic bus;
    logic err;
    logic ovr;
  } trk_t;

endpackage

// File: rtl/can_irq_rst_sync.sv
module can_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SRC   = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0C,
  parameter logic [NUM_SRC-1:0] EN_MASK  = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata_lo,
  input  logic [NUM_SRC-1:0] flag_view,
  output logic [NUM_SRC-1:0] en_q,
  output logic               flag_rd,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               hit_en;
  logic               hit_flag;
  logic               en_ce;
  logic [NUM_SRC-1:0] en_d;
  logic [NUM_SRC-1:0] rsel;
  logic [DATA_W-1:0]  rdata_d;

  // next-state
  always_comb begin
    hit_en   = (addr == EN_ADDR);
    hit_flag = (addr == FLAG_ADDR);
    en_ce    = wr_en && hit_en;
    en_d     = wdata_lo & EN_MASK;
    if (hit_en) begin
      rsel = en_q;
    end else if (hit_flag) begin
      rsel = flag_view;
    end else begin
      rsel = '0;
    end
    rdata_d = {{PAD_W{1'b0}}, rsel};
  end

  assign flag_rd = rd_en && hit_flag;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
    end
  end

endmodule

// File: rtl/can_irq_events.sv
module can_irq_events
  import can_irq_pkg::*;
#(
  parameter trk_t STAT_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trk_t               stat,
  input  logic               tx_done,
  input  logic               arb_lost,
  input  logic               bus_error,
  output logic [NUM_SRC-1:0] evt
);

  trk_t prev_q;
  trk_t rise;
  trk_t chg;

  always_comb begin
    chg  = stat ^ prev_q;
    rise = stat & ~prev_q;
    evt  = '0;
    evt[SRC_TX]   = tx_done | rise.tx_free;
    evt[SRC_WARN] = chg.bus | chg.err;
    evt[SRC_OVR]  = rise.ovr;
    evt[SRC_PASV] = chg.passive;
    evt[SRC_ARB]  = arb_lost;
    evt[SRC_BERR] = bus_error;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= STAT_RST;
    end else begin
      prev_q <= stat;
    end
  end

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] en,
  input  logic               rd_clr,
  input  logic               rx_full,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] flag_view
);

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    if (b == SRC_RX) begin : g_level
      assign flag_q[b]    = 1'b0;
      assign flag_view[b] = rx_full & en[b];
    end else if (b == SRC_RSVD) begin : g_rsvd
      assign flag_q[b]    = 1'b0;
      assign flag_view[b] = 1'b0;
    end else begin : g_latch
      logic set;
      logic ce;
      logic d;
      logic q;
      always_comb begin
        set = evt[b] & en[b];
        ce  = set | rd_clr;
        d   = set;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else if (ce) begin
          q <= d;
        end
      end
      assign flag_q[b]    = q;
      assign flag_view[b] = q;
    end
  end

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0C,
  parameter trk_t        STAT_RST  = '0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              rx_full,
  input  logic              data_overrun,
  input  logic              err_status,
  input  logic              bus_status,
  input  logic              err_passive,
  input  logic              tx_done,
  input  logic              tx_buf_free,
  input  logic              arb_lost,
  input  logic              bus_error,
  output logic              irq_n
);

  logic               rst_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_view;
  logic               flag_rd;
  trk_t               stat;

  always_comb begin
    stat.tx_free = tx_buf_free;
    stat.passive = err_passive;
    stat.bus     = bus_status;
    stat.err     = err_status;
    stat.ovr     = data_overrun;
  end

  can_irq_rst_sync #(.STAGES(2)) rst_i (
    .clk   (clk),
    .arst_n(arst_n),
    .rst_n (rst_q)
  );

  can_irq_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SRC  (NUM_SRC),
    .EN_ADDR  (EN_ADDR),
    .FLAG_ADDR(FLAG_ADDR),
    .EN_MASK  (EN_MASK)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata_lo (reg_wdata[NUM_SRC-1:0]),
    .flag_view(flag_view),
    .en_q     (en_q),
    .flag_rd  (flag_rd),
    .rdata    (reg_rdata),
    .rvalid   (reg_rvalid)
  );

  can_irq_events #(.STAT_RST(STAT_RST)) evt_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .stat     (stat),
    .tx_done  (tx_done),
    .arb_lost (arb_lost),
    .bus_error(bus_error),
    .evt      (evt)
  );

  can_irq_flags flags_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .evt      (evt),
    .en       (en_q),
    .rd_clr   (flag_rd),
    .rx_full  (rx_full),
    .flag_q   (flag_q),
    .flag_view(flag_view)
  );

  assign irq_n = ~(|flag_view);

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        en_q,
  input logic [7:0]        flag_q,
  input logic              irq_n,
  input logic              rx_full,
  input logic              data_overrun,
  input logic              arb_lost,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);

  AST_RSVD_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[4]); // R2

  AST_RX_LEVEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && en_q[0]) |-> !irq_n); // R3

  AST_OVR_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && data_overrun && !$past(data_overrun) && en_q[3]) |=> flag_q[3]); // R6

  AST_ARB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && en_q[6]) |=> flag_q[6]); // R8

  AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[7] && !flag_q[7]) |=> !flag_q[7]); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == FLAG_ADDR && !arb_lost) |=> !flag_q[6]); // R10

  AST_FLAG_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_q) |-> !irq_n); // R11

endmodule

bind can_irq_unit can_irq_chk #(
  .ADDR_W   (ADDR_W),
  .FLAG_ADDR(FLAG_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_q),
  .en_q        (en_q),
  .flag_q      (flag_q),
  .irq_n       (irq_n),
  .rx_full     (rx_full),
  .data_overrun(data_overrun),
  .arb_lost    (arb_lost),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr)
);

// File: tb/can_irq_unit_tb_top.sv
module can_irq_unit_tb_top;

  localparam logic [7:0] A_EN   = 8'h10;
  localparam logic [7:0] A_FLAG = 8'h0C;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        rx_full, data_overrun, err_status, bus_status, err_passive;
  logic        tx_done, tx_buf_free, arb_lost, bus_error;
  logic        irq_n;

  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  can_irq_unit dut_i (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .rx_full(rx_full), .data_overrun(data_overrun),
    .err_status(err_status), .bus_status(bus_status), .err_passive(err_passive),
    .tx_done(tx_done), .tx_buf_free(tx_buf_free), .arb_lost(arb_lost),
    .bus_error(bus_error), .irq_n(irq_n)
  );

  // monitor: pops expected read data as the design returns it
  always @(posedge clk) begin
    #2;
    if (reg_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL unexpected read data: actual=%h expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_err++;
          $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk_pin(input logic exp, input string tag);
    n_chk++;
    if (irq_n !== exp) begin
      n_err++;
      $display("FAIL %s: irq_n actual=%b expected=%b", tag, irq_n, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
    idle(1);
  endtask

  initial begin
    arst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rx_full = 0; data_overrun = 0; err_status = 0; bus_status = 0; err_passive = 0;
    tx_done = 0; tx_buf_free = 0; arb_lost = 0; bus_error = 0;
    idle(4);
    arst_n = 1'b1;
    idle(4);

    // reset state
    chk_pin(1'b1, "R1 pin idle after reset");
    rd(A_EN,   32'h0, "R1 enable reset value");
    rd(A_FLAG, 32'h0, "R1 flag reset value");

    // enable register masking
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, 32'h0000_00EF, "R2 reserved bits read zero");
    wr(A_EN, 32'h0);
    rd(A_EN, 32'h0, "R2 enable cleared");

    // no spurious interrupt with status at reset values
    wr(A_EN, 32'hEF);
    idle(3);
    chk_pin(1'b1, "R12 no spurious interrupt");
    rd(A_FLAG, 32'h0, "R12 flags empty after enabling");

    // receive level
    @(negedge clk); rx_full = 1'b1; #1;
    chk_pin(1'b0, "R3 rx level asserts pin");
    rd(A_FLAG, 32'h01, "R3 rx flag visible");
    rd(A_FLAG, 32'h01, "R3 rx flag not cleared by read");
    chk_pin(1'b0, "R3 pin still low");
    wr(A_EN, 32'hEE);
    chk_pin(1'b1, "R3 pin released after enable cleared");
    rx_full = 1'b0;
    wr(A_EN, 32'hEF);

    // transmit
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk_pin(1'b0, "R4 tx_done sets pin");
    rd(A_FLAG, 32'h02, "R4 tx_done flag");
    chk_pin(1'b1, "R10 pin released after read");
    @(negedge clk); tx_buf_free = 1'b1; idle(1);
    rd(A_FLAG, 32'h02, "R4 tx buffer free rise");
    @(negedge clk); tx_buf_free = 1'b0; idle(1);
    rd(A_FLAG, 32'h00, "R4 tx buffer free fall ignored");

    // warning: both directions of both levels
    @(negedge clk); bus_status = 1'b1; idle(1);
    rd(A_FLAG, 32'h04, "R5 bus status rise");
    @(negedge clk); bus_status = 1'b0; idle(1);
    rd(A_FLAG, 32'h04, "R5 bus status fall");
    @(negedge clk); err_status = 1'b1; idle(1);
    rd(A_FLAG, 32'h04, "R5 error status rise");
    @(negedge clk); err_status = 1'b0; idle(1);
    rd(A_FLAG, 32'h04, "R5 error status fall");

    // overrun rise only
    @(negedge clk); data_overrun = 1'b1; idle(1);
    rd(A_FLAG, 32'h08, "R6 overrun rise");
    @(negedge clk); data_overrun = 1'b0; idle(1);
    rd(A_FLAG, 32'h00, "R6 overrun fall ignored");
    chk_pin(1'b1, "R6 pin high after overrun fall");

    // error passive both directions
    @(negedge clk); err_passive = 1'b1; idle(1);
    rd(A_FLAG, 32'h20, "R7 passive entered");
    @(negedge clk); err_passive = 1'b0; idle(1);
    rd(A_FLAG, 32'h20, "R7 passive left");

    // pulses
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    rd(A_FLAG, 32'h40, "R8 arbitration lost");
    @(negedge clk); bus_error = 1'b1;
    @(negedge clk); bus_error = 1'b0;
    rd(A_FLAG, 32'h80, "R8 bus error");
    @(negedge clk); arb_lost = 1'b1; bus_error = 1'b1;
    @(negedge clk); arb_lost = 1'b0; bus_error = 1'b0;
    rd(A_FLAG, 32'hC0, "R8 both pulses");

    // disabled events dropped
    wr(A_EN, 32'h0);
    @(negedge clk); arb_lost = 1'b1; tx_done = 1'b1; bus_status = 1'b1;
    @(negedge clk); arb_lost = 1'b0; tx_done = 1'b0;
    idle(1);
    @(negedge clk); bus_status = 1'b0; bus_error = 1'b1;
    @(negedge clk); bus_error = 1'b0;
    chk_pin(1'b1, "R9 pin high while disabled");
    wr(A_EN, 32'hEF);
    idle(1);
    chk_pin(1'b1, "R9 no late interrupt after enabling");
    rd(A_FLAG, 32'h00, "R9 dropped events leave no flag");

    // event in the same cycle as a clearing read
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_FLAG; bus_error = 1'b1;
    exp_q.push_back(32'h40); tag_q.push_back("R10 read returns pre-clear value");
    @(negedge clk); reg_rd = 1'b0; bus_error = 1'b0;
    idle(1);
    chk_pin(1'b0, "R10 concurrent event survives read");
    rd(A_FLAG, 32'h80, "R10 only concurrent event left");

    // pin versus combined sources
    @(negedge clk); arb_lost = 1'b1; data_overrun = 1'b1; rx_full = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    rd(A_FLAG, 32'h49, "R11 mixed sources read");
    chk_pin(1'b0, "R11 rx level keeps pin low");
    @(negedge clk); rx_full = 1'b0; #1;
    chk_pin(1'b1, "R11 pin high when nothing set");
    @(negedge clk); data_overrun = 1'b0;
    rd(A_FLAG, 32'h00, "R11 all clear");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL reads outstanding: actual=%0d expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule